// File: doc/BRIEF.md
# Bit Set/Reset and Test Unit

This unit performs single-bit operations on registers held in an external single-port data register file. A caller pulses a start strobe together with an operation code, a register address and a bit index. For a set or reset, the unit reads the register, forces the selected bit to 1 or to 0, and writes the result back. For a test, the unit reads the register and reports whether a branch should be taken. One test variant branches when the bit is clear and the other branches when the bit is set.

The unit also handles the condition flags. Set and reset leave the carry and zero flags unchanged. A test copies the selected bit into carry and leaves zero unchanged. The new flag values and the branch decision are valid in the cycle where the done pulse is high. Working out the branch target and decoding instructions are left to the surrounding logic.

The register file has a synchronous read. Read data for a request made in one cycle is returned in the next cycle.

Top module: `bit_rmw_unit`

## Requirements
- R1: Op code 2'b00 (set) writes the register back with the indexed bit at 1. Op code 2'b01 (reset) writes it back with that bit at 0. All other bits keep their old values.
- R2: Set and reset are accepted at a clock edge. After that edge, the unit issues a register file read in the first cycle and a write in the third cycle. `done_o` is high in the fourth cycle only, and exactly one write is made.
- R3: When set or reset is done, `carry_o` equals `carry_i`, `zero_o` equals `zero_i`, and `branch_o` is 0.
- R4: When a test is done, `branch_o` is 1 in two cases: op code 2'b10 with the indexed bit at 0, or op code 2'b11 with the indexed bit at 1. In all other cases it is 0.
- R5: When a test is done, `carry_o` equals the tested bit and `zero_o` equals `zero_i`.
- R6: A test issues its read in the first cycle after acceptance and raises `done_o` in the fifth cycle only. It never asserts `rf_we_o`.
- R7: A start strobe that arrives while an operation is in progress is ignored. The register it names is not changed, and no additional done pulse follows.
- R8: After reset, `done_o`, `rf_en_o`, `rf_we_o` and `branch_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the unit is idle |
| op_i | input | 2 | 00 set, 01 reset, 10 test branch-if-clear, 11 test branch-if-set |
| addr_i | input | ADDR_W | Register address |
| bit_i | input | IDX_W | Bit index |
| rf_en_o | output | 1 | Register file access enable |
| rf_we_o | output | 1 | Register file write enable |
| rf_addr_o | output | ADDR_W | Register file address |
| rf_wdata_o | output | DATA_W | Register file write data |
| rf_rdata_i | input | DATA_W | Register file read data, valid one cycle after a read |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| carry_o | output | 1 | Next carry flag |
| zero_o | output | 1 | Next zero flag |
| branch_o | output | 1 | Branch condition met, valid with done |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses bit 0 and bit 7 so that an index decoded off by one, or a mask shifted the wrong way, changes a bit the expected value does not allow. Registers holding all ones and all zeros show whether a set or reset disturbs the other bits. Each test is run with the incoming carry set to the opposite of the tested bit, so a design that leaves carry unchanged is caught. The bench also checks the done cycle and the number of writes for both operation lengths, which catches a test that writes, or a sequence that is one cycle short or long. A start strobe is held high in the middle of an operation with a different address; a design that re-arms on it would change the second register or produce a second done.

// File: rtl/bit_rmw_unit.sv
module bit_rmw_unit #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  bit_i,
  output logic              rf_en_o,
  output logic              rf_we_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  input  logic              carry_i,
  input  logic              zero_i,
  output logic              carry_o,
  output logic              zero_o,
  output logic              branch_o,
  output logic              done_o
);
  localparam logic [2:0] PH_RD  = 3'd1;
  localparam logic [2:0] PH_CAP = 3'd2;
  localparam logic [2:0] PH_WR  = 3'd3;
  localparam logic [2:0] PH_SR_END = 3'd4;
  localparam logic [2:0] PH_TS_END = 3'd5;

  logic [2:0]        phase_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  logic              is_test;
  logic [2:0]        last_ph;
  logic [DATA_W-1:0] mask;
  logic              tbit;

  assign is_test = op_q[1];
  assign last_ph = is_test ? PH_TS_END : PH_SR_END;
  assign mask    = DATA_W'(1) << idx_q;
  assign tbit    = data_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      if (phase_q == 3'd0) begin
        if (start_i) begin
          phase_q <= PH_RD;
          op_q    <= op_i;
          addr_q  <= addr_i;
          idx_q   <= bit_i;
        end
      end else if (phase_q == last_ph) begin
        phase_q <= 3'd0;
      end else begin
        phase_q <= phase_q + 3'd1;
      end
      if (phase_q == PH_CAP) data_q <= rf_rdata_i;
    end
  end

  assign rf_we_o    = (phase_q == PH_WR) && !is_test;
  assign rf_en_o    = (phase_q == PH_RD) || rf_we_o;
  assign rf_addr_o  = addr_q;
  assign rf_wdata_o = op_q[0] ? (data_q & ~mask) : (data_q | mask);

  assign done_o   = (phase_q != 3'd0) && (phase_q == last_ph);
  assign carry_o  = (done_o && is_test) ? tbit : carry_i;
  assign zero_o   = zero_i;
  assign branch_o = done_o && is_test && (tbit == op_q[0]);
endmodule

// File: rtl/bit_rmw_unit_chk.sv
module bit_rmw_unit_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2:0]        phase_q,
  input logic [1:0]        op_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] data_q,
  input logic              rf_en_o,
  input logic              rf_we_o,
  input logic [DATA_W-1:0] rf_wdata_o,
  input logic              carry_o,
  input logic              branch_o,
  input logic              done_o
);
  AST_ONE_BIT_CHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni) rf_we_o |-> ($countones(rf_wdata_o ^ data_q) <= 1)); // R1
  AST_WRITE_THEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) rf_we_o |=> done_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R2
  AST_SR_NO_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni) (done_o && !op_q[1]) |-> !branch_o); // R3
  AST_BRANCH_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni) (done_o && op_q[1]) |-> (branch_o == (carry_o == op_q[0]))); // R4
  AST_TEST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni) (phase_q != 3'd0 && op_q[1]) |-> !rf_we_o); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni) (phase_q != 3'd0 && start_i) |=> ($stable(op_q) && $stable(addr_q))); // R7
  AST_WE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni) rf_we_o |-> rf_en_o); // R2
endmodule

bind bit_rmw_unit bit_rmw_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .phase_q(phase_q),
  .op_q(op_q), .addr_q(addr_q), .data_q(data_q), .rf_en_o(rf_en_o),
  .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o), .carry_o(carry_o),
  .branch_o(branch_o), .done_o(done_o)
);

// File: tb/bit_rmw_unit_tb.sv
module bit_rmw_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] addr = '0;
  logic [2:0] bidx = '0;
  logic       cin = 1'b0, zin = 1'b0;
  logic       rf_en, rf_we, cout, zout, branch, done;
  logic [7:0] rf_addr, rf_wdata;
  logic [7:0] rf_rdata = '0;
  logic [7:0] mem [0:255];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_rmw_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
    .bit_i(bidx), .rf_en_o(rf_en), .rf_we_o(rf_we), .rf_addr_o(rf_addr),
    .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata), .carry_i(cin), .zero_i(zin),
    .carry_o(cout), .zero_o(zout), .branch_o(branch), .done_o(done)
  );

  always_ff @(posedge clk) begin
    if (rf_en) begin
      if (rf_we) mem[rf_addr] <= rf_wdata;
      else rf_rdata <= mem[rf_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic run_op(input logic [1:0] o, input logic [7:0] a, input logic [2:0] b,
                        input logic c, input logic z, input bit intrude,
                        output int done_k, output int writes, output bit rd1,
                        output logic c_d, output logic z_d, output logic br_d);
    done_k = 0; writes = 0; rd1 = 0; c_d = 0; z_d = 0; br_d = 0;
    @(negedge clk);
    start = 1'b1; op = o; addr = a; bidx = b; cin = c; zin = z;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (intrude) begin
          op = 2'b01; addr = a + 8'd1; bidx = 3'd5;
        end else start = 1'b0;
        rd1 = rf_en && !rf_we;
      end
      if (k == 3) start = 1'b0;
      if (rf_we) writes++;
      if (done) begin
        if (done_k == 0) begin
          done_k = k; c_d = cout; z_d = zout; br_d = branch;
        end else done_k = 99;
      end
    end
  endtask

  task automatic t_reset_state();
    chk(!done && !rf_en && !rf_we && !branch, "R8 reset outputs",
        {done, rf_en, rf_we, branch}, 0);
  endtask

  task automatic t_setres(input logic [1:0] o, input logic [7:0] a, input logic [7:0] init,
                          input logic [2:0] b, input logic c, input logic z);
    int dk, wr; bit rd; logic cd, zd, bd; logic [7:0] exp;
    mem[a] = init;
    exp = o[0] ? (init & ~(8'd1 << b)) : (init | (8'd1 << b));
    run_op(o, a, b, c, z, 0, dk, wr, rd, cd, zd, bd);
    chk(mem[a] == exp, "R1 written value", mem[a], exp);
    chk(dk == 4 && wr == 1 && rd, "R2 done cycle/writes", dk * 16 + wr, 4 * 16 + 1);
    chk(cd == c && zd == z && !bd, "R3 flags kept", {cd, zd, bd}, {c, z, 1'b0});
  endtask

  task automatic t_test(input logic [1:0] o, input logic [7:0] a, input logic [7:0] init,
                        input logic [2:0] b, input logic z);
    int dk, wr; bit rd; logic cd, zd, bd; logic tb, eb;
    mem[a] = init;
    tb = init[b];
    eb = o[0] ? tb : !tb;
    run_op(o, a, b, !tb, z, 0, dk, wr, rd, cd, zd, bd);
    chk(bd == eb, "R4 branch condition", bd, eb);
    chk(cd == tb && zd == z, "R5 carry/zero", {cd, zd}, {tb, z});
    chk(dk == 5 && wr == 0 && rd && mem[a] == init, "R6 timing/no write",
        dk * 16 + wr, 5 * 16);
  endtask

  task automatic t_busy_start();
    int dk, wr; bit rd; logic cd, zd, bd;
    mem[8'h40] = 8'h00;
    mem[8'h41] = 8'hFF;
    run_op(2'b00, 8'h40, 3'd2, 1'b0, 1'b0, 1, dk, wr, rd, cd, zd, bd);
    chk(mem[8'h40] == 8'h04, "R7 first op completes", mem[8'h40], 8'h04);
    chk(mem[8'h41] == 8'hFF, "R7 intruding op ignored", mem[8'h41], 8'hFF);
    chk(dk == 4 && wr == 1, "R7 single done", dk * 16 + wr, 4 * 16 + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    #(CLK_PERIOD * 2 + 1);
    t_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    t_setres(2'b00, 8'h10, 8'h00, 3'd0, 1'b1, 1'b0);
    t_setres(2'b00, 8'h11, 8'h5A, 3'd7, 1'b0, 1'b1);
    t_setres(2'b01, 8'h12, 8'hFF, 3'd7, 1'b1, 1'b1);
    t_setres(2'b01, 8'h13, 8'hA5, 3'd0, 1'b0, 1'b0);
    t_test(2'b10, 8'h20, 8'hFE, 3'd0, 1'b1);
    t_test(2'b10, 8'h21, 8'h80, 3'd7, 1'b0);
    t_test(2'b11, 8'h22, 8'h80, 3'd7, 1'b1);
    t_test(2'b11, 8'h23, 8'h7F, 3'd7, 1'b0);
    t_test(2'b11, 8'h24, 8'h08, 3'd3, 1'b0);
    t_busy_start();
    summary();
    $finish;
  end
endmodule